// File: doc/BRIEF.md
# Cancellable Register Slice

This block is one register stage placed between a producer and a consumer. Both sides use a valid/ready handshake, and the stage carries a payload whose width is a parameter. The consumer can also cancel the transaction the stage currently holds. A cancelled transaction is dropped and never reaches the output.

The stage has three status outputs that surrounding logic uses to commit or undo work:

- **firing** means the held item is delivered this cycle.
- **moving** means the item will be gone from the stage from the next cycle on, either delivered or cancelled.
- **canceling** means the item is being discarded.

The stage is accepting whenever it is empty, so a bubble is always filled. It is also accepting whenever the held item is leaving.

Top module: `cancel_stage`

## Requirements
- R1: Reset is asynchronous and active high. While reset is applied and after it is released, `downValid` is 0 and `upReady` is 1.
- R2: `upReady` is 1 whenever any one of these holds: the stage holds no valid item, `downReady` is 1, or `downCancel` is 1. Otherwise `upReady` is 0.
- R3: When `upValid` and `upReady` are both 1 at a clock edge, `downValid` is 1 after that edge and `downData` equals the `upData` sampled at the edge.
- R4: While `downValid` is 1 and neither `downReady` nor `downCancel` is 1, `downValid` stays 1 and `downData` stays unchanged across the edge.
- R5: `isFiring` is 1 exactly when `downValid` is 1, `downReady` is 1 and `downCancel` is 0. An item counts as delivered only in such a cycle.
- R6: `isMoving` is 1 exactly when `downValid` is 1 and at least one of `downReady` and `downCancel` is 1. `downValid` can only fall after a cycle in which `isMoving` was 1.
- R7: `isCanceling` is 1 exactly when `downValid` and `downCancel` are both 1, whatever the value of `downReady`.
- R8: After a cycle in which the held item is cancelled, `downValid` is 0 if no new item was accepted in that cycle. If a new item was accepted in that same cycle, the stage holds the new item.
- R9: While `downValid` is 0, the values on `downReady` and `downCancel` have no effect. All three status flags are 0 and `upReady` is 1.
- R10: Under random stalls and random cancels, every accepted item is either delivered or cancelled exactly once, in the order it was accepted. No cancelled item ever appears at a delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| upValid | input | 1 | Producer has an item |
| upReady | output | 1 | Stage accepts an item this cycle |
| upData | input | DATA_W | Producer payload |
| downValid | output | 1 | Stage holds an item |
| downReady | input | 1 | Consumer takes the held item |
| downCancel | input | 1 | Consumer discards the held item |
| downData | output | DATA_W | Held payload |
| isFiring | output | 1 | Held item delivered this cycle |
| isMoving | output | 1 | Held item leaves the stage after this cycle |
| isCanceling | output | 1 | Held item discarded this cycle |

## Verification
The hardest case to reach is a cancel that lands in the same cycle as a new upstream item, while the consumer is stalled. In that case the stage must replace the item rather than drop the new one. A directed task loads an item and holds `downReady` low. It then raises `downCancel` and `upValid` together and checks that the new payload is held afterwards.

A random phase covers the remaining interleavings. It mixes stalls, cancels and producer gaps, and compares every delivery against a scoreboard of accepted items.

// File: rtl/cps_pkg.sv
package cps_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture upstream payload this cycle
  } stage_strobe_t;
endpackage

// File: rtl/cps_ctrl.sv
module cps_ctrl
  import cps_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          upValid,
  input  logic          downReady,
  input  logic          downCancel,
  output logic          upReady,
  output logic          heldValid,
  output stage_strobe_t strobe,
  output logic          isFiring,
  output logic          isMoving,
  output logic          isCanceling
);
  logic vldQ;

  always_comb begin
    isFiring    = vldQ & downReady & ~downCancel;
    isCanceling = vldQ & downCancel;
    isMoving    = vldQ & (downReady | downCancel);
    upReady     = ~vldQ | isMoving;
    strobe.load = upReady;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          vldQ <= 1'b0;
    else if (upReady) vldQ <= upValid;
  end

  assign heldValid = vldQ;

  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    upValid && upReady |=> heldValid);

  p_cancel_clear_r8: assert property (@(posedge clk) disable iff (rst)
    isCanceling && !upValid |=> !heldValid);

  p_fire_excl_r5: assert property (@(posedge clk) disable iff (rst)
    isFiring |-> !isCanceling && isMoving);

  p_drop_rule_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(heldValid) |-> $past(isMoving));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !heldValid |-> !isFiring && !isMoving && !isCanceling && upReady);
endmodule

// File: rtl/cps_data.sv
module cps_data
  import cps_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  stage_strobe_t       strobe,
  input  logic [DATA_W-1:0]   upData,
  output logic [DATA_W-1:0]   downData
);
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (strobe.load) dataQ <= upData;
  end

  assign downData = dataQ;
endmodule

// File: rtl/cancel_stage.sv
module cancel_stage
  import cps_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upValid,
  output logic              upReady,
  input  logic [DATA_W-1:0] upData,
  output logic              downValid,
  input  logic              downReady,
  input  logic              downCancel,
  output logic [DATA_W-1:0] downData,
  output logic              isFiring,
  output logic              isMoving,
  output logic              isCanceling
);
  stage_strobe_t strobe;

  cps_ctrl u_ctrl (
    .clk(clk), .rst(rst), .upValid(upValid), .downReady(downReady),
    .downCancel(downCancel), .upReady(upReady), .heldValid(downValid),
    .strobe(strobe), .isFiring(isFiring), .isMoving(isMoving),
    .isCanceling(isCanceling)
  );

  cps_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .strobe(strobe), .upData(upData), .downData(downData)
  );

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    downValid && !downReady && !downCancel |=> downValid && $stable(downData));

  p_load_data_r3: assert property (@(posedge clk) disable iff (rst)
    upValid && upReady |=> downData == $past(upData));
endmodule

// File: tb/cancel_stage_tb.sv
module cancel_stage_tb;
  localparam int W = 16;
  localparam int N = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upValid = 1'b0;
  logic [W-1:0] upData = '0;
  logic downReady = 1'b0;
  logic downCancel = 1'b0;
  logic upReady, downValid, isFiring, isMoving, isCanceling;
  logic [W-1:0] downData;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cancel_stage #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .upValid(upValid), .upReady(upReady), .upData(upData),
    .downValid(downValid), .downReady(downReady), .downCancel(downCancel),
    .downData(downData), .isFiring(isFiring), .isMoving(isMoving),
    .isCanceling(isCanceling)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    check(downValid == 1'b0, "R1 valid in reset", downValid, 0);
    check(upReady == 1'b1, "R1 ready in reset", upReady, 1);
    rst = 1'b0;
    step();
    check(downValid == 1'b0, "R1 valid after reset", downValid, 0);
    check(upReady == 1'b1, "R1 ready after reset", upReady, 1);
  endtask

  task automatic t_pass();
    upValid = 1'b1; upData = 16'hA1A1; downReady = 1'b1;
    step();
    check(downValid == 1'b1, "R3 valid", downValid, 1);
    check(downData == 16'hA1A1, "R3 data", downData, 16'hA1A1);
    check(isFiring == 1'b1, "R5 firing", isFiring, 1);
    check(isMoving == 1'b1, "R6 moving", isMoving, 1);
    check(upReady == 1'b1, "R2 ready passes through", upReady, 1);
  endtask

  task automatic t_stall();
    upData = 16'hB2B2; upValid = 1'b1; downReady = 1'b1;
    step();
    downReady = 1'b0; upData = 16'hC3C3;
    #1;
    check(upReady == 1'b0, "R2 stalled ready", upReady, 0);
    check(isFiring == 1'b0, "R5 no fire when stalled", isFiring, 0);
    check(isMoving == 1'b0, "R6 no move when stalled", isMoving, 0);
    step();
    check(downValid == 1'b1, "R4 valid held", downValid, 1);
    check(downData == 16'hB2B2, "R4 data held", downData, 16'hB2B2);
    downReady = 1'b1;
    step();
    check(downData == 16'hC3C3, "R3 next after stall", downData, 16'hC3C3);
    upValid = 1'b0;
    step();
    check(downValid == 1'b0, "R6 drains", downValid, 0);
  endtask

  task automatic t_cancel();
    upValid = 1'b1; upData = 16'hD4D4; downReady = 1'b0;
    step();
    upValid = 1'b0; downCancel = 1'b1;
    #1;
    check(isCanceling == 1'b1, "R7 canceling", isCanceling, 1);
    check(isMoving == 1'b1, "R6 moving on cancel", isMoving, 1);
    check(isFiring == 1'b0, "R5 no fire on cancel", isFiring, 0);
    check(upReady == 1'b1, "R2 ready on cancel", upReady, 1);
    step();
    downCancel = 1'b0;
    check(downValid == 1'b0, "R8 cancelled item cleared", downValid, 0);
    upValid = 1'b1; upData = 16'hE5E5;
    step();
    // same-cycle cancel and capture, with consumer ready high
    upData = 16'hF6F6; downCancel = 1'b1; downReady = 1'b1;
    #1;
    check(isCanceling == 1'b1, "R7 canceling with ready", isCanceling, 1);
    check(isFiring == 1'b0, "R5 cancel beats ready", isFiring, 0);
    step();
    check(downValid == 1'b1 && downData == 16'hF6F6, "R8 replace on cancel",
          downData, 16'hF6F6);
    // same-cycle cancel and capture while consumer stalled
    upData = 16'h0707; downReady = 1'b0;
    step();
    check(downValid == 1'b1 && downData == 16'h0707, "R8 replace while stalled",
          downData, 16'h0707);
    upValid = 1'b0;
    step();
    downCancel = 1'b0;
    check(downValid == 1'b0, "R8 cleared", downValid, 0);
  endtask

  task automatic t_idle();
    upValid = 1'b0; downReady = 1'b0; downCancel = 1'b1;
    #1;
    check({isFiring, isMoving, isCanceling} == 3'b000, "R9 flags idle",
          {isFiring, isMoving, isCanceling}, 0);
    check(upReady == 1'b1, "R9 ready idle", upReady, 1);
    downReady = 1'b1; downCancel = 1'b0;
    step();
    check(downValid == 1'b0, "R9 stays empty", downValid, 0);
    downReady = 1'b0;
  endtask

  task automatic t_random();
    logic [W-1:0] q [0:511];
    int head = 0;
    int tail = 0;
    int sent = 0;
    int delivered = 0;
    int dropped = 0;
    int cyc = 0;
    logic acc;
    upValid = 1'b0; downCancel = 1'b0; downReady = 1'b0;
    while ((head < N || sent < N) && cyc < 20000) begin
      cyc++;
      if (!upValid && sent < N && ($urandom % 3) != 0) begin
        upValid = 1'b1; upData = W'(sent + 16'h100); sent++;
      end
      downReady = 1'($urandom % 2);
      downCancel = (($urandom % 6) == 0);
      #1;
      if (downValid) begin
        check(head < tail && downData == q[head[8:0]], "R10 order", downData,
              q[head[8:0]]);
        if (downCancel) begin head++; dropped++; end
        else if (downReady) begin head++; delivered++; end
      end
      acc = upValid & upReady;
      if (acc) begin q[tail[8:0]] = upData; tail++; end
      step();
      if (acc) upValid = 1'b0;
    end
    downCancel = 1'b0; downReady = 1'b0;
    check(delivered + dropped == N && head == tail, "R10 all accounted",
          delivered + dropped, N);
    check(delivered > 0 && dropped > 0, "R10 mix seen", dropped, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #7;
    t_reset();
    t_pass();
    t_stall();
    t_cancel();
    t_idle();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule